// File: doc/BRIEF.md
# SPI Interrupt Cause Latch

This unit sits beside a FIFO-based SPI master. It gathers the master's live condition flags into one status word and turns each flag into an interrupt cause. A cause latches only on a 0-to-1 change of its flag. The unit also computes the two FIFO ready flags from byte counts and programmable thresholds.

A mask register selects which causes drive the single interrupt line. Software clears a cause by writing 1 to it. A flag that is already high when software clears or unmasks its cause raises nothing until the flag falls and rises again.

Software reaches four word registers over a simple 32-bit register bus. The bus selects a register with a 2-bit index. Reads are combinational while `bus_req_i` is high and `bus_we_i` is low; at any other time the read data is zero. Writes take effect at the next clock edge.

Top module: `spi_irq_status`

## Requirements
- R1: Register index 0 reads the live status word, bits 31:12 zero. The bit positions are:
  - bit 0: transfer done.
  - bit 1: transfer ready.
  - bit 2: read-FIFO ready.
  - bit 3: write-FIFO ready.
  - bits 11:4: `fifo_flags_i[7:0]`, in this order from bit 4 up: read-FIFO empty, read-FIFO full, write-FIFO empty, write-FIFO full, read-FIFO underflow, read-FIFO overflow, write-FIFO underflow, write-FIFO overflow.
- R2: Status bit 2 is high exactly when `rd_fill_i` is greater than the read threshold held in bits 26:24 of register index 1.
- R3: Status bit 3 is high exactly when `wr_free_i` is greater than the write threshold held in bits 30:28 of register index 1.
- R4: A cause bit sets after the clock edge at which its status bit is first seen high after being low. A status bit that stays high sets nothing new.
- R5: Writing register index 2 clears each cause bit whose data bit is 1. Data bits of 0 leave causes untouched, and all ones clears every cause.
- R6: If a status bit rises in the same cycle as a clear write to its cause bit, the cause bit stays set.
- R7: `irq_o` is high when any cause bit is also set in the mask register (index 3, bits 11:0). A zero mask holds `irq_o` low.
- R8: Unmasking a cause whose flag is already high does not raise `irq_o`, provided that cause was cleared.
- R9: Reset clears the cause, mask and threshold registers and the stored flag history.
- R10: Register index 1 reads back only the two threshold fields. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_done_i | input | 1 | Transfer done flag |
| xfer_rdy_i | input | 1 | Transfer ready flag |
| fifo_flags_i | input | 8 | Empty, full, underflow and overflow flags of both FIFOs |
| rd_fill_i | input | OCC_W | Bytes held in the read FIFO |
| wr_free_i | input | OCC_W | Free bytes in the write FIFO |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | Write enable |
| bus_addr_i | input | 2 | Register index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench uses the default `OCC_W` of 4. With that width, the fill and free counts range from 0 to 15, above the largest threshold of 7, so both ready comparators can be driven to either side of every threshold setting. The flag word width is fixed at 12 by the status layout. This lets random stimulus toggle every cause bit and mask bit, including rises that land in the same cycle as clear writes.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int FLAG_W       = 12;
  localparam int FIFO_FLAG_W  = 8;
  localparam int THR_W        = 3;
  localparam int RD_THR_LSB   = 24;
  localparam int WR_THR_LSB   = 28;
  localparam int REG_IDX_W    = 2;
  localparam int DATA_W       = 32;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_STATUS = 2'd0,
    REG_CFG    = 2'd1,
    REG_CAUSE  = 2'd2,
    REG_MASK   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [THR_W-1:0] wr_thr;
    logic [THR_W-1:0] rd_thr;
  } thr_cfg_t;
endpackage

// File: rtl/spi_fifo_ready.sv
module spi_fifo_ready #(
  parameter int LVL_W = 4,
  parameter int THR_W = 3
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             rdy_o
);
  localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [CMP_W-1:0] level_x, thr_x;

  assign level_x = CMP_W'(level_i);
  assign thr_x   = CMP_W'(thr_i);
  assign rdy_o   = level_x > thr_x;
endmodule

// File: rtl/spi_irq_cause.sv
module spi_irq_cause #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic rise;
    assign rise = flags_i[i] & ~prev_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[i]  <= 1'b0;
        cause_o[i] <= 1'b0;
      end else begin
        prev_q[i]  <= flags_i[i];
        // a new edge outranks a concurrent clear
        cause_o[i] <= rise | (cause_o[i] & ~clr_i[i]);
      end
    end
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int OCC_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   xfer_done_i,
  input  logic                   xfer_rdy_i,
  input  logic [FIFO_FLAG_W-1:0] fifo_flags_i,
  input  logic [OCC_W-1:0]       rd_fill_i,
  input  logic [OCC_W-1:0]       wr_free_i,
  input  logic                   bus_req_i,
  input  logic                   bus_we_i,
  input  logic [REG_IDX_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]      bus_wdata_i,
  output logic [DATA_W-1:0]      bus_rdata_o,
  output logic                   irq_o
);
  thr_cfg_t          cfg_q;
  logic [FLAG_W-1:0] mask_q, cause_q, status_w, clr_w;
  logic              rd_rdy, wr_rdy, wr_en, rd_en;
  reg_sel_e          sel;
  logic              unused_wdata;

  assign sel   = reg_sel_e'(bus_addr_i);
  assign wr_en = bus_req_i & bus_we_i;
  assign rd_en = bus_req_i & ~bus_we_i;

  spi_fifo_ready #(.LVL_W(OCC_W), .THR_W(THR_W)) u_rd_rdy (
    .level_i (rd_fill_i),
    .thr_i   (cfg_q.rd_thr),
    .rdy_o   (rd_rdy)
  );

  spi_fifo_ready #(.LVL_W(OCC_W), .THR_W(THR_W)) u_wr_rdy (
    .level_i (wr_free_i),
    .thr_i   (cfg_q.wr_thr),
    .rdy_o   (wr_rdy)
  );

  assign status_w = {fifo_flags_i, wr_rdy, rd_rdy, xfer_rdy_i, xfer_done_i};
  assign clr_w    = (wr_en && sel == REG_CAUSE) ? bus_wdata_i[FLAG_W-1:0] : '0;

  spi_irq_cause #(.W(FLAG_W)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (status_w),
    .clr_i   (clr_w),
    .cause_o (cause_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (sel == REG_CFG) begin
        cfg_q.rd_thr <= bus_wdata_i[RD_THR_LSB +: THR_W];
        cfg_q.wr_thr <= bus_wdata_i[WR_THR_LSB +: THR_W];
      end
      if (sel == REG_MASK) mask_q <= bus_wdata_i[FLAG_W-1:0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      unique case (sel)
        REG_STATUS: bus_rdata_o[FLAG_W-1:0] = status_w;
        REG_CFG: begin
          bus_rdata_o[RD_THR_LSB +: THR_W] = cfg_q.rd_thr;
          bus_rdata_o[WR_THR_LSB +: THR_W] = cfg_q.wr_thr;
        end
        REG_CAUSE:  bus_rdata_o[FLAG_W-1:0] = cause_q;
        REG_MASK:   bus_rdata_o[FLAG_W-1:0] = mask_q;
        default:    bus_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(cause_q & mask_q);

  assign unused_wdata = ^{bus_wdata_i[DATA_W-1], bus_wdata_i[WR_THR_LSB-1],
                          bus_wdata_i[RD_THR_LSB-1:FLAG_W]};
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk #(
  parameter int FLAG_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FLAG_W-1:0] status_i,
  input logic [FLAG_W-1:0] cause_i,
  input logic [FLAG_W-1:0] mask_i,
  input logic [FLAG_W-1:0] clr_i,
  input logic              irq_i
);
  logic [FLAG_W-1:0] hist_q, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= status_i;
  end
  assign rise = status_i & ~hist_q;

  p_rise_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((cause_i & $past(rise)) == $past(rise)));

  p_no_spurious_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i & ~$past(cause_i) & ~$past(rise)) == '0);

  p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((cause_i & $past(clr_i & ~rise)) == '0));

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & rise)) |=> ((cause_i & $past(clr_i & rise)) == $past(clr_i & rise)));

  p_mask_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_i);
endmodule

bind spi_irq_status spi_irq_status_chk #(.FLAG_W(spi_irq_pkg::FLAG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .status_i (status_w),
  .cause_i  (cause_q),
  .mask_i   (mask_q),
  .clr_i    (clr_w),
  .irq_i    (irq_o)
);

// File: tb/spi_irq_status_test.sv
module spi_irq_status_test;
  localparam int OCC_W = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xfer_done = 1'b0, xfer_rdy = 1'b0;
  logic [7:0]  fifo_flags = '0;
  logic [OCC_W-1:0] rd_fill = '0, wr_free = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  logic [11:0] m_cause = '0, m_mask = '0, m_prev = '0;
  logic [2:0]  m_rthr = '0, m_wthr = '0;

  always #5 clk = ~clk;

  spi_irq_status #(.OCC_W(OCC_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .xfer_done_i(xfer_done), .xfer_rdy_i(xfer_rdy),
    .fifo_flags_i(fifo_flags), .rd_fill_i(rd_fill), .wr_free_i(wr_free),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  function automatic logic [11:0] exp_status();
    logic rr, wr;
    rr = int'(rd_fill) > int'(m_rthr);
    wr = int'(wr_free) > int'(m_wthr);
    return {fifo_flags, wr, rr, xfer_rdy, xfer_done};
  endfunction

  function automatic logic [31:0] exp_cfg();
    return {1'b0, m_wthr, 1'b0, m_rthr, 24'h0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with the current inputs and bus request, model follows the requirements
  task automatic tick();
    logic [11:0] st, rise, clr;
    st   = exp_status();
    rise = st & ~m_prev;
    clr  = (bus_req && bus_we && bus_addr == 2'd2) ? bus_wdata[11:0] : 12'h0;
    @(posedge clk);
    m_cause = rise | (m_cause & ~clr);
    m_prev  = st;
    if (bus_req && bus_we && bus_addr == 2'd3) m_mask = bus_wdata[11:0];
    if (bus_req && bus_we && bus_addr == 2'd1) begin
      m_rthr = bus_wdata[26:24];
      m_wthr = bus_wdata[30:28];
    end
    @(negedge clk);
    bus_req = 1'b0;
    bus_we  = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
    bus_req = 1'b0;
  endtask

  task automatic irq_chk(string req);
    chk(req, {31'b0, irq}, {31'b0, |(m_cause & m_mask)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R9 reset state
    rd_chk("R9", 2'd0, 32'h0);
    rd_chk("R9", 2'd1, 32'h0);
    rd_chk("R9", 2'd2, 32'h0);
    rd_chk("R9", 2'd3, 32'h0);
    chk("R9", {31'b0, irq}, 32'h0);

    // R10 only the two threshold fields stick
    wr(2'd1, 32'hFFFF_FFFF);
    rd_chk("R10", 2'd1, 32'h7700_0000);
    wr(2'd1, 32'h4300_0000);
    rd_chk("R10", 2'd1, exp_cfg());

    // R1 layout
    fifo_flags = 8'hA5; xfer_rdy = 1'b1;
    rd_chk("R1", 2'd0, {20'h0, 8'hA5, 4'b0010});
    tick();

    // R2 read threshold 3: ready needs more than 3 bytes
    rd_fill = 4'd3;
    rd_chk("R2", 2'd0, {20'h0, exp_status()});
    chk("R2", {31'b0, bus_rdata[2]}, 32'h0);
    rd_fill = 4'd4;
    rd_chk("R2", 2'd0, {20'h0, exp_status()});
    chk("R2", {31'b0, bus_rdata[2]}, 32'h1);
    tick();

    // R3 write threshold 4
    wr_free = 4'd4;
    rd_chk("R3", 2'd0, {20'h0, exp_status()});
    chk("R3", {31'b0, bus_rdata[3]}, 32'h0);
    wr_free = 4'd5;
    rd_chk("R3", 2'd0, {20'h0, exp_status()});
    chk("R3", {31'b0, bus_rdata[3]}, 32'h1);
    tick();
    wr(2'd2, 32'hFFFF_FFFF);
    rd_chk("R5", 2'd2, 32'h0);

    // R4 rise sets, steady high sets nothing after clear
    xfer_done = 1'b1;
    tick();
    rd_chk("R4", 2'd2, 32'h1);
    wr(2'd2, 32'h1);
    tick();
    rd_chk("R4", 2'd2, 32'h0);

    // R8 unmask while flag high
    wr(2'd3, 32'h1);
    chk("R8", {31'b0, irq}, 32'h0);

    // R6 rise and clear in the same cycle
    xfer_done = 1'b0;
    tick();
    xfer_done = 1'b1;
    wr(2'd2, 32'h1);
    rd_chk("R6", 2'd2, 32'h1);
    chk("R7", {31'b0, irq}, 32'h1);

    // R7 zero mask silences
    wr(2'd3, 32'h0);
    chk("R7", {31'b0, irq}, 32'h0);

    // R5 zero write keeps, all ones clears
    wr(2'd2, 32'h0);
    rd_chk("R5", 2'd2, 32'h1);
    wr(2'd2, 32'hFFFF_FFFF);
    rd_chk("R5", 2'd2, 32'h0);

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int op;
      if (($urandom % 4) == 0) xfer_done = $urandom;
      if (($urandom % 4) == 0) xfer_rdy = $urandom;
      if (($urandom % 3) == 0) fifo_flags = fifo_flags ^ (8'h1 << ($urandom % 8));
      if (($urandom % 3) == 0) rd_fill = $urandom;
      if (($urandom % 3) == 0) wr_free = $urandom;
      rd_chk("R1", 2'd0, {20'h0, exp_status()});
      op = $urandom % 6;
      case (op)
        0: wr(2'd2, $urandom);
        1: wr(2'd3, $urandom);
        2: wr(2'd1, $urandom);
        3: begin
          // clear exactly the bits that rise now
          bus_req = 1'b1; bus_we = 1'b1; bus_addr = 2'd2;
          bus_wdata = {20'h0, exp_status() & ~m_prev};
          tick();
        end
        default: tick();
      endcase
      rd_chk("R4", 2'd2, {20'h0, m_cause});
      irq_chk("R7");
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule